// File: doc/BRIEF.md
# Two-Wire Serial Clock Divider Search Engine

This block works out the divider settings for the clock generator of a two-wire serial master. Given a reference clock frequency and a wanted SCL frequency, it tries combinations of three divider fields: a half-period count, an M prescaler and a power-of-two N prescaler. It returns the setting whose SCL rate comes closest to the target, together with the remaining error in hertz. Software or a boot sequencer pulses start once and waits for the one-cycle done strobe. The result fields stay on the outputs for the clock generator to use.

Two arithmetic variants are supported and chosen per search by a mode input. In paired mode each SCL half-period is `2*(thp+1)` reference cycles, and the M prescaler is kept at 2 or more. In direct mode each SCL period is `thp+2` reference cycles, and M may go down to 0. The engine walks N upward and M downward. For each (M, N) pair it tests the two half-period values that lie either side of the ideal one. It rejects half-period values outside the 5..255 window and stops as soon as an exact match has been found. All quotients come from one shared iterative divider. The target frequency is assumed to be nonzero.

Top module: `scl_div_search`

## Requirements
- R1: While reset is held and after it is released, busy_o and done_o are 0 and thp_o, mdiv_o, ndiv_o and err_o are all 0.
- R2: A start_i pulse seen while busy_o is 0 captures mode_i, ref_hz_i and target_hz_i. busy_o is then 1 from the next cycle until the search ends.
- R3: A start_i pulse while busy_o is 1 is ignored. Changes on mode_i, ref_hz_i or target_hz_i during a search do not affect its result.
- R4: done_o is a single-cycle pulse in the first cycle where busy_o is 0 again. A start_i pulse in that same cycle is accepted.
- R5: thp_o, mdiv_o, ndiv_o and err_o change only in the done_o cycle and otherwise hold their value.
- R6: Paired mode (mode_i=0). N steps 0 up to 7 (outer loop). M steps 15 down to 2 (inner loop). tclk = target*(M+1)*10*2^N, base = floor(ref/(2*tclk)) - 1, and the achieved rate for a half-period h is floor(floor(floor(ref/(2*(h+1)))/2^N)/(M+1))/10 (each step truncates).
- R7: Direct mode (mode_i=1). The loops are the same as in R6, except M steps down to 0. base = floor(ref/tclk) - 2, and the achieved rate uses floor(ref/(h+2)) in place of floor(ref/(2*(h+1))).
- R8: For each pair, h = base and h = base+1 are tried, and only if 5 <= h <= 255. A candidate replaces the kept best only if its absolute error is strictly smaller, so the first of equal errors wins. err_o is the absolute difference between the chosen achieved rate and the target.
- R9: If no candidate has an error below 1,000,000 Hz, the outputs are thp_o = 0x18 (paired) or 0x03 (direct), mdiv_o = 2, ndiv_o = 0 and err_o = 1000000.
- R10: Once the kept error reaches 0, no further (M, N) pairs are visited. An early exact match therefore finishes in a small fraction of the time of a full walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, acted on only while idle |
| mode_i | input | 1 | 0 = paired arithmetic, 1 = direct arithmetic |
| ref_hz_i | input | 32 | Reference clock frequency in Hz |
| target_hz_i | input | 32 | Wanted SCL frequency in Hz (nonzero) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion strobe |
| thp_o | output | 8 | Chosen half-period count |
| mdiv_o | output | 4 | Chosen M prescaler |
| ndiv_o | output | 3 | Chosen N exponent |
| err_o | output | 32 | Absolute error of the chosen setting in Hz |

## Verification
The completion strobe and the acceptance of a new start can fall in the same cycle. The bench provokes this by watching for done_o just after a clock edge and raising start_i, with new operands, before the next edge. It then judges both events: the finished result must match the behavioural model of the first operands, and busy_o must rise the following cycle. The second result must match the model of the new operands. A start raised in the middle of a search, with operands changed while busy, is also checked: it must leave the running result untouched.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   typedef enum logic [0:0] {
      DIV_MODE_PAIRED = 1'b0,
      DIV_MODE_DIRECT = 1'b1
   } div_mode_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_BASE_GO,
      S_BASE_WAIT,
      S_CAND,
      S_FREQ_WAIT,
      S_STEP,
      S_FINISH
   } srch_state_e;

endpackage

// File: rtl/scl_div_divider.sv
module scl_div_divider #(
   parameter int NUM_W = 32,
   parameter int DEN_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);

   localparam int CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;
   localparam int PRD_W = NUM_W + DEN_W + 1;

   generate
      if (NUM_W < 2) begin : g_bad_num
         $error("scl_div_divider: NUM_W must be at least 2");
      end
      if (DEN_W < 2) begin : g_bad_den
         $error("scl_div_divider: DEN_W must be at least 2");
      end
   endgenerate

   logic [DEN_W:0]   rem_q;
   logic [NUM_W-1:0] quo_q;
   logic [NUM_W-1:0] num_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             done_q;

   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
   assign fits  = (trial >= {1'b0, den_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         num_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run_q) begin
            if (go_i) begin
               rem_q <= '0;
               quo_q <= num_i;
               num_q <= num_i;
               den_q <= den_i;
               cnt_q <= CNT_W'(NUM_W - 1);
               run_q <= 1'b1;
            end
         end else begin
            if (fits) begin
               rem_q <= trial - {1'b0, den_q};
               quo_q <= {quo_q[NUM_W-2:0], 1'b1};
            end else begin
               rem_q <= trial;
               quo_q <= {quo_q[NUM_W-2:0], 1'b0};
            end
            if (cnt_q == '0) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign busy_o = run_q;
   assign done_o = done_q;
   assign quo_o  = quo_q;

   // R8: every quotient handed to the search obeys num = quo*den + rem, rem < den
   p_div_quotient_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && den_q != '0) |->
         ((PRD_W'(quo_q) * PRD_W'(den_q) + PRD_W'(rem_q) == PRD_W'(num_q))
          && (rem_q < {1'b0, den_q})));

   // R8: the strobe is one cycle wide and the divider is idle with it
   p_div_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/scl_div_err_cmp.sv
module scl_div_err_cmp #(
   parameter int W = 32
) (
   input  logic [W-1:0] achieved_i,
   input  logic [W-1:0] target_i,
   input  logic [W-1:0] best_i,
   output logic [W-1:0] diff_o,
   output logic         better_o
);

   generate
      if (W < 8) begin : g_bad_w
         $error("scl_div_err_cmp: W must be at least 8");
      end
   endgenerate

   always_comb begin
      if (achieved_i >= target_i) diff_o = achieved_i - target_i;
      else                        diff_o = target_i - achieved_i;
      better_o = (diff_o < best_i);
   end

endmodule

// File: rtl/scl_div_search.sv
module scl_div_search
   import scl_div_pkg::*;
#(
   parameter int FREQ_W            = 32,
   parameter int THP_W             = 8,
   parameter int MDIV_W            = 4,
   parameter int NDIV_W            = 3,
   parameter int THP_LO            = 5,
   parameter int INIT_ERR          = 1_000_000,
   parameter int PAIRED_THP_DEF    = 24,
   parameter int DIRECT_THP_DEF    = 3,
   parameter int DEF_MDIV          = 2,
   parameter int PAIRED_MDIV_FLOOR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [FREQ_W-1:0] ref_hz_i,
   input  logic [FREQ_W-1:0] target_hz_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [THP_W-1:0]  thp_o,
   output logic [MDIV_W-1:0] mdiv_o,
   output logic [NDIV_W-1:0] ndiv_o,
   output logic [FREQ_W-1:0] err_o
);

   localparam int THP_HI   = (1 << THP_W) - 1;
   localparam int MDIV_TOP = (1 << MDIV_W) - 1;
   localparam int NDIV_TOP = (1 << NDIV_W) - 1;
   localparam int DEN_W    = FREQ_W + (MDIV_W + 1) + 4 + NDIV_TOP + 1;
   localparam int EXT_W    = FREQ_W + 1;

   generate
      if (THP_LO < 1 || THP_LO > THP_HI) begin : g_bad_lo
         $error("scl_div_search: THP_LO outside the half-period range");
      end
      if (FREQ_W < $clog2(INIT_ERR + 1)) begin : g_bad_err
         $error("scl_div_search: FREQ_W too narrow for INIT_ERR");
      end
      if (PAIRED_MDIV_FLOOR > MDIV_TOP || DEF_MDIV > MDIV_TOP) begin : g_bad_m
         $error("scl_div_search: M limits exceed the M field");
      end
      if (PAIRED_THP_DEF > THP_HI || DIRECT_THP_DEF > THP_HI) begin : g_bad_def
         $error("scl_div_search: default half-period exceeds the field");
      end
   endgenerate

   srch_state_e       state_q;
   div_mode_e         mode_q;
   logic [FREQ_W-1:0] ref_q;
   logic [FREQ_W-1:0] tgt_q;
   logic [MDIV_W-1:0] mdiv_q;
   logic [NDIV_W-1:0] ndiv_q;
   logic              inc_q;
   logic [FREQ_W-1:0] base_q;
   logic [THP_W-1:0]  best_thp_q;
   logic [MDIV_W-1:0] best_mdiv_q;
   logic [NDIV_W-1:0] best_ndiv_q;
   logic [FREQ_W-1:0] best_err_q;
   logic              done_q;
   logic [THP_W-1:0]  thp_q;
   logic [MDIV_W-1:0] mdiv_out_q;
   logic [NDIV_W-1:0] ndiv_out_q;
   logic [FREQ_W-1:0] err_q;

   // divisor construction
   logic [DEN_W-1:0]  m_scale;
   logic [DEN_W-1:0]  tclk_raw;
   logic [DEN_W-1:0]  tclk_den;
   logic [DEN_W-1:0]  period_w;
   logic [DEN_W-1:0]  freq_den;
   logic [EXT_W-1:0]  off_w;
   logic [EXT_W-1:0]  base_plus;
   logic [EXT_W-1:0]  lo_lim;
   logic [EXT_W-1:0]  hi_lim;
   logic              cand_ok;
   logic [THP_W-1:0]  cand_thp;
   logic [MDIV_W-1:0] m_floor;

   assign m_scale   = DEN_W'(mdiv_q) + DEN_W'(1);
   assign tclk_raw  = (DEN_W'(tgt_q) * m_scale * DEN_W'(10)) << ndiv_q;
   assign tclk_den  = (mode_q == DIV_MODE_DIRECT) ? tclk_raw : (tclk_raw << 1);

   assign off_w     = (mode_q == DIV_MODE_DIRECT) ? EXT_W'(2) : EXT_W'(1);
   assign base_plus = {1'b0, base_q} + EXT_W'(inc_q);
   assign lo_lim    = EXT_W'(THP_LO) + off_w;
   assign hi_lim    = EXT_W'(THP_HI) + off_w;
   assign cand_ok   = (base_plus >= lo_lim) && (base_plus <= hi_lim);
   assign cand_thp  = THP_W'(base_plus - off_w);

   assign period_w  = (mode_q == DIV_MODE_DIRECT) ?
                      (DEN_W'(cand_thp) + DEN_W'(2)) :
                      ((DEN_W'(cand_thp) + DEN_W'(1)) << 1);
   assign freq_den  = (period_w * m_scale * DEN_W'(10)) << ndiv_q;

   assign m_floor   = (mode_q == DIV_MODE_DIRECT) ? '0 : MDIV_W'(PAIRED_MDIV_FLOOR);

   // shared divider
   logic              div_go;
   logic [DEN_W-1:0]  div_den;
   logic              div_busy;
   logic              div_done;
   logic [FREQ_W-1:0] div_quo;

   assign div_go  = (state_q == S_BASE_GO) || ((state_q == S_CAND) && cand_ok);
   assign div_den = (state_q == S_BASE_GO) ? tclk_den : freq_den;

   scl_div_divider #(
      .NUM_W (FREQ_W),
      .DEN_W (DEN_W)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (ref_q),
      .den_i  (div_den),
      .busy_o (div_busy),
      .done_o (div_done),
      .quo_o  (div_quo)
   );

   logic [FREQ_W-1:0] cand_err;
   logic              cand_better;

   scl_div_err_cmp #(
      .W (FREQ_W)
   ) u_cmp (
      .achieved_i (div_quo),
      .target_i   (tgt_q),
      .best_i     (best_err_q),
      .diff_o     (cand_err),
      .better_o   (cand_better)
   );

   // search sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         mode_q      <= DIV_MODE_PAIRED;
         ref_q       <= '0;
         tgt_q       <= '0;
         mdiv_q      <= '0;
         ndiv_q      <= '0;
         inc_q       <= 1'b0;
         base_q      <= '0;
         best_thp_q  <= '0;
         best_mdiv_q <= '0;
         best_ndiv_q <= '0;
         best_err_q  <= '0;
         done_q      <= 1'b0;
         thp_q       <= '0;
         mdiv_out_q  <= '0;
         ndiv_out_q  <= '0;
         err_q       <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  mode_q      <= mode_i ? DIV_MODE_DIRECT : DIV_MODE_PAIRED;
                  ref_q       <= ref_hz_i;
                  tgt_q       <= target_hz_i;
                  mdiv_q      <= MDIV_W'(MDIV_TOP);
                  ndiv_q      <= '0;
                  inc_q       <= 1'b0;
                  best_err_q  <= FREQ_W'(INIT_ERR);
                  best_thp_q  <= mode_i ? THP_W'(DIRECT_THP_DEF) : THP_W'(PAIRED_THP_DEF);
                  best_mdiv_q <= MDIV_W'(DEF_MDIV);
                  best_ndiv_q <= '0;
                  state_q     <= S_BASE_GO;
               end
            end
            S_BASE_GO: begin
               state_q <= S_BASE_WAIT;
            end
            S_BASE_WAIT: begin
               if (div_done) begin
                  base_q  <= div_quo;
                  inc_q   <= 1'b0;
                  state_q <= S_CAND;
               end
            end
            S_CAND: begin
               state_q <= cand_ok ? S_FREQ_WAIT : S_STEP;
            end
            S_FREQ_WAIT: begin
               if (div_done) begin
                  if (cand_better) begin
                     best_err_q  <= cand_err;
                     best_thp_q  <= cand_thp;
                     best_mdiv_q <= mdiv_q;
                     best_ndiv_q <= ndiv_q;
                  end
                  state_q <= S_STEP;
               end
            end
            S_STEP: begin
               if (!inc_q) begin
                  inc_q   <= 1'b1;
                  state_q <= S_CAND;
               end else if (best_err_q == '0) begin
                  state_q <= S_FINISH;
               end else if (mdiv_q > m_floor) begin
                  mdiv_q  <= mdiv_q - 1'b1;
                  inc_q   <= 1'b0;
                  state_q <= S_BASE_GO;
               end else if (ndiv_q != NDIV_W'(NDIV_TOP)) begin
                  ndiv_q  <= ndiv_q + 1'b1;
                  mdiv_q  <= MDIV_W'(MDIV_TOP);
                  inc_q   <= 1'b0;
                  state_q <= S_BASE_GO;
               end else begin
                  state_q <= S_FINISH;
               end
            end
            S_FINISH: begin
               thp_q      <= best_thp_q;
               mdiv_out_q <= best_mdiv_q;
               ndiv_out_q <= best_ndiv_q;
               err_q      <= best_err_q;
               done_q     <= 1'b1;
               state_q    <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != S_IDLE);
   assign done_o = done_q;
   assign thp_o  = thp_q;
   assign mdiv_o = mdiv_out_q;
   assign ndiv_o = ndiv_out_q;
   assign err_o  = err_q;

   // R2: an idle start launches a search
   p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   // R3: a start during a search leaves the captured operands alone
   p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(ref_q) && $stable(tgt_q) && $stable(mode_q)));

   // R4: strobe is one cycle and coincides with idle
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R5: results hold outside the strobe cycle
   p_hold_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(thp_o) && $stable(mdiv_o) && $stable(ndiv_o) && $stable(err_o)));

   // R6: paired mode never reports M below its floor
   p_paired_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q == DIV_MODE_PAIRED) |-> (mdiv_o >= MDIV_W'(PAIRED_MDIV_FLOOR)));

   // R8: a found setting lies inside the half-period window, error never grows
   p_thp_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o != FREQ_W'(INIT_ERR)) |->
         (thp_o >= THP_W'(THP_LO) && err_o < FREQ_W'(INIT_ERR)));
   p_div_idle_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
      div_go |-> !div_busy);

   // R9: no improvement leaves the mode default fields
   p_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o == FREQ_W'(INIT_ERR)) |->
         (mdiv_o == MDIV_W'(DEF_MDIV) && ndiv_o == '0 &&
          thp_o == ((mode_q == DIV_MODE_DIRECT) ? THP_W'(DIRECT_THP_DEF)
                                                : THP_W'(PAIRED_THP_DEF))));

endmodule

// File: tb/scl_div_search_tb.sv
module scl_div_search_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        mode_i = 1'b0;
   logic [31:0] ref_hz_i = '0;
   logic [31:0] target_hz_i = '0;
   logic        busy_o;
   logic        done_o;
   logic [7:0]  thp_o;
   logic [3:0]  mdiv_o;
   logic [2:0]  ndiv_o;
   logic [31:0] err_o;

   always #4 clk = ~clk;   // 125 MHz

   scl_div_search dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .mode_i      (mode_i),
      .ref_hz_i    (ref_hz_i),
      .target_hz_i (target_hz_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .thp_o       (thp_o),
      .mdiv_o      (mdiv_o),
      .ndiv_o      (ndiv_o),
      .err_o       (err_o)
   );

   int     n_checks = 0;
   int     n_fail   = 0;
   bit     finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // behavioural model of the search loop
   function automatic void ref_model(input bit md, input longint rf, input longint tg,
                                     output int o_thp, output int o_m, output int o_n,
                                     output longint o_err);
      longint best;
      int     bt, bm, bn;
      best = 1000000;
      bt   = md ? 3 : 24;
      bm   = 2;
      bn   = 0;
      for (int ni = 0; ni < 8 && best != 0; ni++) begin
         for (int mi = 15; mi >= (md ? 0 : 2) && best != 0; mi--) begin
            longint tclk, base, cand, f, d;
            tclk = tg * (mi + 1) * 10 * (longint'(1) << ni);
            base = md ? (rf / tclk - 2) : (rf / (tclk * 2) - 1);
            for (int inc = 0; inc < 2; inc++) begin
               cand = base + inc;
               if (cand >= 5 && cand <= 255) begin
                  f = md ? rf / (cand + 2) : rf / (2 * (cand + 1));
                  f = f / (longint'(1) << ni);
                  f = f / (mi + 1);
                  f = f / 10;
                  d = (f > tg) ? f - tg : tg - f;
                  if (d < best) begin
                     best = d;
                     bt   = int'(cand);
                     bm   = mi;
                     bn   = ni;
                  end
               end
            end
         end
      end
      o_thp = bt;
      o_m   = bm;
      o_n   = bn;
      o_err = best;
   endfunction

   // per-clock monitor
   bit     pending   = 1'b0;
   bit     prev_done = 1'b0;
   bit     cap_mode  = 1'b0;
   longint cap_ref   = 0;
   longint cap_tgt   = 0;
   longint h_thp = 0, h_m = 0, h_n = 0, h_err = 0;
   longint cyc = 0, lat_start = 0, last_lat = 0;

   always @(negedge clk) begin
      int     e_thp, e_m, e_n;
      longint e_err;
      cyc++;
      if (rst_n) begin
         if (done_o) begin
            chk(!prev_done, "R4", "done width", prev_done, 0);
            chk(!busy_o, "R4", "busy in done cycle", busy_o, 0);
            chk(pending, "R2", "done without accepted start", pending, 1);
            ref_model(cap_mode, cap_ref, cap_tgt, e_thp, e_m, e_n, e_err);
            chk(thp_o == e_thp, cap_mode ? "R7" : "R6", "thp", thp_o, e_thp);
            chk(mdiv_o == e_m, cap_mode ? "R7" : "R6", "mdiv", mdiv_o, e_m);
            chk(ndiv_o == e_n, "R8", "ndiv", ndiv_o, e_n);
            chk(err_o == e_err, "R8", "err", err_o, e_err);
            h_thp = thp_o; h_m = mdiv_o; h_n = ndiv_o; h_err = err_o;
            pending  = 1'b0;
            last_lat = cyc - lat_start;
         end else begin
            chk(busy_o == pending, "R2", "busy", busy_o, pending);
            chk(thp_o == h_thp && mdiv_o == h_m && ndiv_o == h_n && err_o == h_err,
                "R5", "held thp", thp_o, h_thp);
         end
         prev_done = done_o;
         if (start_i && !busy_o) begin
            cap_mode  = mode_i;
            cap_ref   = ref_hz_i;
            cap_tgt   = target_hz_i;
            pending   = 1'b1;
            lat_start = cyc;
         end
      end
   end

   task automatic launch(input bit md, input longint rf, input longint tg);
      @(posedge clk); #1;
      mode_i      = md;
      ref_hz_i    = 32'(rf);
      target_hz_i = 32'(tg);
      start_i     = 1'b1;
      @(posedge clk); #1;
      start_i     = 1'b0;
   endtask

   task automatic wait_done();
      do begin
         @(posedge clk); #1;
      end while (!done_o);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      finish_run();
   end

   initial begin
      longint lat_exact, lat_default;
      int     e_thp, e_m, e_n;
      longint e_err;

      repeat (3) @(posedge clk);
      #1;
      chk(!busy_o && !done_o, "R1", "flags in reset", {busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(thp_o == 0 && mdiv_o == 0 && ndiv_o == 0 && err_o == 0,
          "R1", "fields after reset", err_o, 0);
      chk(!busy_o, "R1", "busy after reset", busy_o, 0);

      // paired, exact match early in the walk
      launch(1'b0, 700000000, 100000);
      wait_done();
      lat_exact = last_lat;
      chk(err_o == 0, "R10", "exact paired err", err_o, 0);

      // paired, nothing reachable: defaults
      launch(1'b0, 100000000, 50000000);
      wait_done();
      lat_default = last_lat;
      chk(thp_o == 8'h18 && mdiv_o == 2 && ndiv_o == 0, "R9", "paired default thp", thp_o, 24);
      chk(err_o == 1000000, "R9", "paired default err", err_o, 1000000);
      chk(lat_exact * 4 < lat_default, "R10", "early exit latency", lat_exact, lat_default / 4);

      // direct, exact match
      launch(1'b1, 100000000, 100000);
      wait_done();
      chk(err_o == 0, "R7", "direct exact err", err_o, 0);

      // direct, nothing reachable: defaults
      launch(1'b1, 100000000, 40000000);
      wait_done();
      chk(thp_o == 8'h03 && mdiv_o == 2 && ndiv_o == 0, "R9", "direct default thp", thp_o, 3);

      // general operand pairs
      launch(1'b0, 600000000, 375000);
      wait_done();
      launch(1'b1, 33333333, 347000);
      wait_done();

      // start during a search with operands changed while busy
      launch(1'b0, 700000000, 230000);
      repeat (40) @(posedge clk);
      #1;
      mode_i = 1'b1; ref_hz_i = 32'd5000000; target_hz_i = 32'd7000; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      chk(busy_o, "R3", "busy kept through ignored start", busy_o, 1);
      ref_hz_i = 32'd123456789; target_hz_i = 32'd55555;
      wait_done();
      ref_model(1'b0, 700000000, 230000, e_thp, e_m, e_n, e_err);
      chk(thp_o == e_thp && err_o == e_err, "R3", "result of first operands", err_o, e_err);

      // start in the same cycle as done
      launch(1'b1, 100000000, 400000);
      wait_done();
      mode_i = 1'b0; ref_hz_i = 32'd800000000; target_hz_i = 32'd400000; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      chk(busy_o, "R4", "start in done cycle accepted", busy_o, 1);
      wait_done();
      ref_model(1'b0, 800000000, 400000, e_thp, e_m, e_n, e_err);
      chk(thp_o == e_thp && mdiv_o == e_m, "R4", "back-to-back result", thp_o, e_thp);

      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule